// File: doc/BRIEF.md
# Host memory access port

This block gives an external host direct access to two on-chip memories of a processor. One is a program store of 24-bit words and the other a data store of 16-bit words. The host uses a 16-bit bus with select, address-latch, read and write strobes, which the port samples on its own clock. The port answers with an active-low ready line. The core takes no part in a transfer, and no interrupt is raised. The host first latches a 15-bit pointer. Bit 14 picks the store and bits 13:0 pick the word. After that, the host streams reads or writes and the pointer advances by itself.

A program word crosses the 16-bit bus as two accesses: the upper sixteen bits first, then the low byte right-justified. The pointer moves only after the second access. A data word takes one access. In boot mode, the first completed write of program word 0 ends booting and emits a one-cycle start pulse to the core. The ready line is the only flow control. While it is high, every strobe is dropped, so the host must see it low before it strobes. Each store is a small synchronous array, and a location is taken modulo the array depth.

Top module: `hostmem_port`

## Requirements
- R1: After reset the ready line `hack_n` is 0, `run_start` is 0, `hdata_out` is 0, the pointer addresses program word 0, and the next program access is the upper half.
- R2: A latch is taken when `hsel` and `hlatch` are both high in a clock cycle while ready. It loads `hdata_in[14:0]` into the pointer: bit 14 = 0 selects program memory, bit 14 = 1 selects data memory, and bits 13:0 are the word location. Accesses to one store never change the other.
- R3: A program-memory write takes two accesses. The first supplies bits 23:8 of the word. The second supplies bits 7:0 from `hdata_in[7:0]`, and `hdata_in[15:8]` of that access is ignored.
- R4: Program-memory reads return bits 23:8 on the first access and `{8'h00, bits 7:0}` on the second. The pointer advances only after the second access of each word.
- R5: A data-memory read or write moves one 16-bit word per access, and the pointer advances after every access.
- R6: A latch resets the half tracker, so the next program access is taken as the upper half even if a lower half was pending.
- R7: `hack_n` goes high in the cycle after an accepted read or write and stays high for exactly BUSY_CYC cycles (default 3) before it returns low. A read or write strobe seen while `hack_n` is high has no effect.
- R8: Strobes with `hsel` low have no effect, whether they are latch, read or write strobes.
- R9: With `boot_en` high, the completing (second) write to program location 0 drives `run_start` high for one cycle, in the cycle after that access. Later writes to location 0 give no pulse, and no pulse occurs while `boot_en` is low.
- R10: The 14-bit location wraps from 0x3FFF to 0 and the store-select bit is kept.
- R11: Read data appears on `hdata_out` in the cycle after the read is accepted and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_en | input | 1 | Boot mode: allows the start pulse |
| hsel | input | 1 | Host select, qualifies all strobes |
| hlatch | input | 1 | Address-latch strobe |
| hrd | input | 1 | Read strobe |
| hwr | input | 1 | Write strobe (wins over a read) |
| hdata_in | input | 16 | Host bus, address or write data |
| hdata_out | output | 16 | Read data toward the host |
| hack_n | output | 1 | Low when the port is ready, high while busy |
| run_start | output | 1 | One-cycle start pulse when booting ends |

## Verification
Program words are written with junk in the upper byte of the second access and read back in pairs. The pairs separate a correct split and zero-fill from a swapped or unmasked half. A latch issued in the middle of a word shows whether the half tracker resets. A write to the same location in the other store shows whether the stores are kept apart. Data-memory bursts through location 0x3FFF show the wrap and whether the select bit is kept. Strobes sent with select low, or while the port is busy, are followed by reads that expose any pointer or memory change they caused. Writes to program location 0 are made with boot mode off, then on, then on a second time, and the number of start pulses is counted.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
  localparam int HBUS_W = 16;
  localparam int LOC_W  = 14;
  localparam int PM_W   = 24;
  localparam int LO_W   = PM_W - HBUS_W;

  typedef struct packed {
    logic             dm;
    logic [LOC_W-1:0] loc;
  } hptr_t;

  typedef enum logic {PH_HI = 1'b0, PH_LO = 1'b1} half_e;
endpackage

// File: rtl/hmp_sram.sv
module hmp_sram #(
  parameter int W     = 16,
  parameter int DEPTH = 256,
  parameter int AW    = 14
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr % DEPTH] <= wdata;
    if (re) rdata <= mem[addr % DEPTH];
  end
endmodule

// File: rtl/hmp_ack_timer.sv
module hmp_ack_timer #(
  parameter int BUSY_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (start)      cnt_q <= CW'(BUSY_CYC);
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  AST_BUSY_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R7
  AST_NO_ACCESS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start); // R7
endmodule

// File: rtl/hmp_sequencer.sv
module hmp_sequencer
  import hmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_en,
  input  logic              hsel,
  input  logic              hlatch,
  input  logic              hrd,
  input  logic              hwr,
  input  logic [HBUS_W-1:0] hdata_in,
  input  logic              busy,
  output logic [LOC_W-1:0]  loc,
  output logic              pm_we,
  output logic [PM_W-1:0]   pm_wdata,
  output logic              dm_we,
  output logic              pm_re,
  output logic              dm_re,
  output logic              rd_lo,
  output logic              acc_start,
  output logic              run_start
);
  hptr_t              ptr_q;
  half_e              half_q;
  logic [HBUS_W-1:0]  hi_buf_q;
  logic               boot_done_q;
  logic               run_start_q;

  logic do_latch, do_acc, is_wr, lo, word_done, boot_hit;

  assign do_latch  = hsel && hlatch && !busy;
  assign do_acc    = hsel && (hrd || hwr) && !hlatch && !busy;
  assign is_wr     = hwr;
  assign lo        = (half_q == PH_LO);
  assign word_done = do_acc && (ptr_q.dm || lo);

  assign loc       = ptr_q.loc;
  assign pm_we     = do_acc && is_wr && !ptr_q.dm && lo;
  assign pm_wdata  = {hi_buf_q, hdata_in[LO_W-1:0]};
  assign dm_we     = do_acc && is_wr && ptr_q.dm;
  assign pm_re     = do_acc && !is_wr && !ptr_q.dm;
  assign dm_re     = do_acc && !is_wr && ptr_q.dm;
  assign rd_lo     = lo;
  assign acc_start = do_acc;
  assign boot_hit  = pm_we && boot_en && !boot_done_q && (ptr_q.loc == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q       <= '0;
      half_q      <= PH_HI;
      hi_buf_q    <= '0;
      boot_done_q <= 1'b0;
      run_start_q <= 1'b0;
    end else begin
      run_start_q <= boot_hit;
      if (boot_hit) boot_done_q <= 1'b1;
      if (do_latch) begin
        ptr_q  <= hptr_t'(hdata_in[LOC_W:0]);
        half_q <= PH_HI;
      end else if (do_acc) begin
        if (word_done) ptr_q.loc <= ptr_q.loc + 1'b1;
        if (!ptr_q.dm) half_q <= lo ? PH_HI : PH_LO;
        if (is_wr && !ptr_q.dm && !lo) hi_buf_q <= hdata_in;
      end
    end
  end

  assign run_start = run_start_q;

  AST_PM_HOLD_ON_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (do_acc && !ptr_q.dm && half_q == PH_HI) |=> (ptr_q == $past(ptr_q))); // R4
  AST_DM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (do_acc && ptr_q.dm) |=> (ptr_q.loc == LOC_W'($past(ptr_q.loc) + 1'b1) && ptr_q.dm)); // R5
  AST_LATCH_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    do_latch |=> (half_q == PH_HI)); // R6
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    run_start_q |=> !run_start_q); // R9
  AST_NO_SEL_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    !hsel |=> (ptr_q == $past(ptr_q) && half_q == $past(half_q))); // R8
endmodule

// File: rtl/hostmem_port.sv
module hostmem_port
  import hmp_pkg::*;
#(
  parameter int PM_DEPTH = 256,
  parameter int DM_DEPTH = 256,
  parameter int BUSY_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_en,
  input  logic              hsel,
  input  logic              hlatch,
  input  logic              hrd,
  input  logic              hwr,
  input  logic [HBUS_W-1:0] hdata_in,
  output logic [HBUS_W-1:0] hdata_out,
  output logic              hack_n,
  output logic              run_start
);
  logic [LOC_W-1:0]  loc;
  logic              pm_we, dm_we, pm_re, dm_re, rd_lo, acc_start, busy;
  logic [PM_W-1:0]   pm_wdata, pm_rdata;
  logic [HBUS_W-1:0] dm_rdata;
  logic              rd_valid_q, rd_dm_q, rd_lo_q;

  hmp_sequencer u_seq (
    .clk, .rst_n, .boot_en, .hsel, .hlatch, .hrd, .hwr, .hdata_in, .busy,
    .loc, .pm_we, .pm_wdata, .dm_we, .pm_re, .dm_re, .rd_lo, .acc_start,
    .run_start
  );

  hmp_ack_timer #(.BUSY_CYC(BUSY_CYC)) u_ack (
    .clk, .rst_n, .start(acc_start), .busy
  );

  hmp_sram #(.W(PM_W), .DEPTH(PM_DEPTH), .AW(LOC_W)) u_pm (
    .clk, .addr(loc), .we(pm_we), .wdata(pm_wdata), .re(pm_re), .rdata(pm_rdata)
  );

  hmp_sram #(.W(HBUS_W), .DEPTH(DM_DEPTH), .AW(LOC_W)) u_dm (
    .clk, .addr(loc), .we(dm_we), .wdata(hdata_in), .re(dm_re), .rdata(dm_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_dm_q    <= 1'b0;
      rd_lo_q    <= 1'b0;
    end else if (pm_re || dm_re) begin
      rd_valid_q <= 1'b1;
      rd_dm_q    <= dm_re;
      rd_lo_q    <= rd_lo;
    end
  end

  always_comb begin
    if (!rd_valid_q)  hdata_out = '0;
    else if (rd_dm_q) hdata_out = dm_rdata;
    else if (rd_lo_q) hdata_out = {{(HBUS_W-LO_W){1'b0}}, pm_rdata[LO_W-1:0]};
    else              hdata_out = pm_rdata[PM_W-1:LO_W];
  end

  assign hack_n = busy;

  AST_LO_HALF_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_q && !rd_dm_q && rd_lo_q) |-> (hdata_out[HBUS_W-1:LO_W] == '0)); // R4
  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_q && !pm_re && !dm_re && !pm_we && !dm_we) |=> $stable(hdata_out)); // R11
endmodule

// File: tb/hostmem_port_test.sv
`timescale 1ns/1ps
module hostmem_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_en = 1'b0, hsel = 1'b0, hlatch = 1'b0, hrd = 1'b0, hwr = 1'b0;
  logic [15:0] hdata_in = '0;
  logic [15:0] hdata_out;
  logic hack_n, run_start;

  int n_chk = 0, n_fail = 0, start_cnt = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  event        rd_evt;

  always #2 clk = ~clk;

  hostmem_port uut (
    .clk, .rst_n, .boot_en, .hsel, .hlatch, .hrd, .hwr, .hdata_in,
    .hdata_out, .hack_n, .run_start
  );

  always @(negedge clk) if (rst_n && run_start) start_cnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard on every issued read
  initial forever begin
    @(rd_evt);
    begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(hdata_out === e, t, hdata_out, e);
    end
  end

  task automatic wait_ready();
    while (hack_n) @(negedge clk);
  endtask

  task automatic latch(input logic [15:0] a, input logic sel = 1'b1);
    wait_ready();
    hsel = sel; hlatch = 1'b1; hdata_in = a;
    @(negedge clk);
    hsel = 1'b0; hlatch = 1'b0;
  endtask

  task automatic wr_nowait(input logic [15:0] d, input logic sel = 1'b1);
    hsel = sel; hwr = 1'b1; hdata_in = d;
    @(negedge clk);
    hsel = 1'b0; hwr = 1'b0;
  endtask

  task automatic wr(input logic [15:0] d, input logic sel = 1'b1);
    wait_ready();
    wr_nowait(d, sel);
  endtask

  task automatic rd(input logic [15:0] e, input string t);
    wait_ready();
    exp_q.push_back(e); tag_q.push_back(t);
    hsel = 1'b1; hrd = 1'b1;
    @(negedge clk);
    hsel = 1'b0; hrd = 1'b0;
    -> rd_evt;
    #0;
  endtask

  initial begin
    #(200000 * 4);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int busy_len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(hack_n === 1'b0, "R1 ready", hack_n, 0);
    check(run_start === 1'b0, "R1 start", run_start, 0);
    check(hdata_out === 16'h0, "R1 data", hdata_out, 0);

    // R9: no pulse with boot_en low
    latch(16'h0000); wr(16'h0A0B); wr(16'h000C);
    wait_ready();
    check(start_cnt == 0, "R9 no boot", start_cnt, 0);
    latch(16'h0000);
    rd(16'h0A0B, "R1 R4 pm0 hi"); rd(16'h000C, "R4 pm0 lo");

    // R3/R4 program words, junk in upper byte of low access
    latch(16'h0001);
    wr(16'h1234); wr(16'hAB56); wr(16'h789A); wr(16'hFFBC);
    latch(16'h0001);
    rd(16'h1234, "R4 hi 1"); rd(16'h0056, "R3 lo 1");
    rd(16'h789A, "R4 hi 2"); rd(16'h00BC, "R3 lo 2");

    // R6 latch resets half tracker
    latch(16'h0010); wr(16'hDEAD);
    latch(16'h0010); wr(16'hBEEF); wr(16'h0001);
    latch(16'h0010);
    rd(16'hBEEF, "R6 hi"); rd(16'h0001, "R6 lo");

    // R2 R5 data memory, separation from program memory
    latch(16'h0020); wr(16'h0102); wr(16'h0003);
    latch(16'h4020); wr(16'h1357); wr(16'h2468); wr(16'hFFFF);
    latch(16'h4020);
    rd(16'h1357, "R5 dm0"); rd(16'h2468, "R5 dm1"); rd(16'hFFFF, "R5 dm2");
    latch(16'h0020);
    rd(16'h0102, "R2 pm kept hi"); rd(16'h0003, "R2 pm kept lo");

    // R8 strobes without select
    latch(16'h4030); wr(16'h5555); wr(16'h6666);
    latch(16'h4030);
    latch(16'h4031, 1'b0);
    wr(16'h9999, 1'b0);
    rd(16'h5555, "R8 sel low");
    rd(16'h6666, "R8 next");

    // R7 busy length and strobes while busy
    latch(16'h4040); wr(16'h0000); wr(16'h0C0C);
    latch(16'h4040);
    wait_ready();
    wr_nowait(16'h0A0A);
    wr_nowait(16'h0B0B); // lands while busy
    busy_len = 1;
    while (hack_n) begin busy_len++; @(negedge clk); end
    check(busy_len == 3, "R7 busy cycles", busy_len, 3);
    latch(16'h4040);
    rd(16'h0A0A, "R7 first");
    rd(16'h0C0C, "R7 busy write dropped");

    // R10 wrap keeps store select
    latch(16'h7FFF); wr(16'h7777); wr(16'h8888);
    latch(16'h4000);
    rd(16'h8888, "R10 wrap");
    latch(16'h7FFF);
    rd(16'h7777, "R10 top");
    check(start_cnt == 0, "R10 R9 no pulse", start_cnt, 0);

    // R9 boot pulse
    boot_en = 1'b1;
    latch(16'h0000);
    wr(16'h0D0E);
    check(run_start === 1'b0, "R9 not on upper", run_start, 0);
    wr(16'h000F);
    check(run_start === 1'b1, "R9 pulse", run_start, 1);
    @(negedge clk);
    check(run_start === 1'b0, "R9 one cycle", run_start, 0);
    latch(16'h0000); wr(16'h1111); wr(16'h0022);
    wait_ready();
    check(start_cnt == 1, "R9 only once", start_cnt, 1);
    latch(16'h0000);
    rd(16'h1111, "R11 hi"); rd(16'h0022, "R11 lo");
    repeat (2) @(negedge clk);
    check(hdata_out === 16'h0022, "R11 hold", hdata_out, 16'h0022);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule